// File: doc/BRIEF.md
# Justified Dot-Period Pulse Width Modulator

This block is a fully digital pulse width modulator for a print-engine dot stream. It runs on a fast clock. A one-cycle dot strobe marks the start of each dot period, and the block splits that period into 256 sub-slots of one clock each. On every strobe the block takes in an 8-bit width code and two placement selects. It then drives a single output pulse whose length in sub-slots equals the code. The pulse can sit against the start of the period (left-justified), against its end (right-justified), or in its middle (centred).

Code and placement may change on every dot period, and the latency is always one period. Code 0 gives an output that stays low for the whole period, and the all-ones code gives an output that stays high for the whole period. Because of this, a full right-justified pulse followed by a full left-justified pulse makes one continuous high level. A retrace input forces the output high so that the beam can be detected at end of scan. An active-low power-reduce input parks the output low and freezes the sub-slot counter.

Top module: `pwm_justify`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `pwm_out` is 0. The sub-slot index starts at 0.
- R2: Left-justified placement is selected by `single_edge`=1 and `lead_edge`=0. With a code w from 1 to 254, the output is high in sub-slots 0 to w-1 and low in all other sub-slots.
- R3: Right-justified placement is selected by `single_edge`=1 and `lead_edge`=1. With a code w from 1 to 254, the output is high in sub-slots 256-w to 255 and low in all other sub-slots.
- R4: Centred placement is selected by `single_edge`=0, and `lead_edge` is then ignored. With a code w from 1 to 254, the output is high from sub-slot 128-floor(w/2) for w sub-slots. For odd w, the extra sub-slot therefore falls after the centre.
- R5: Code 0 gives an output low in all 256 sub-slots, and code 255 gives an output high in all 256 sub-slots, for every placement.
- R6: Code and selects are sampled on the clock edge where `dot_start`=1. They govern the period that begins at the next strobe, which is one period of latency. Sub-slot s is the (s+1)-th clock cycle after the strobe edge, and `pwm_out` shows sub-slot s during that cycle.
- R7: Code and placement may differ on every period, with no idle period needed between them.
- R8: When `retrace`=1 is sampled on an edge, `pwm_out` is 1 after that edge. When `retrace` returns to 0, the output follows the data path again from the next edge.
- R9: When `low_power_n`=0 is sampled on an edge, `pwm_out` is 0 after that edge. While it stays low, the sub-slot index holds and a strobe does not restart it. Strobes still load code and selects.
- R10: A right-justified full pulse followed by a left-justified full pulse keeps `pwm_out` high across the period boundary with no low cycle. The same holds for any right-justified pulse followed by any left-justified pulse.
- R11: Power-reduce takes priority over retrace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-slot clock |
| rst | input | 1 | Synchronous reset, active high |
| dot_start | input | 1 | One-cycle strobe marking a dot period start |
| width_code | input | 8 | Pulse width in sub-slots, unsigned |
| single_edge | input | 1 | 1: one edge modulated, 0: centred |
| lead_edge | input | 1 | With single_edge=1: 1 right-justified, 0 left-justified |
| retrace | input | 1 | Forces output high |
| low_power_n | input | 1 | Power-reduce, active low: parks output, freezes counter |
| pwm_out | output | 1 | Registered modulated pulse |

## Verification
If the sub-slot index or the two-stage command pipeline were wrong, every modulated edge would be placed at the wrong slot. That error shows up on the output in the first period that carries a code from 1 to 254, within 256 cycles at most. The bench compares the output every clock against a behavioural per-period model. A lost stage would move a pulse by one whole period, and a wrong centred rounding would move an edge by one slot. Either is caught in the first affected period. A wrong priority between retrace and power-reduce shows one cycle after the two are asserted together.

// File: rtl/pwm_just_pkg.sv
package pwm_just_pkg;

    parameter int CODE_W = 8;
    localparam int SLOT_W = CODE_W;
    localparam logic [CODE_W:0] SLOTS_X = (CODE_W+1)'(1) << CODE_W;
    localparam logic [CODE_W:0] HALF_X  = (CODE_W+1)'(1) << (CODE_W-1);
    localparam logic [CODE_W-1:0] CODE_FULL = '1;
    localparam logic [CODE_W-1:0] CODE_NONE = '0;

    typedef enum logic [1:0] {
        JUST_LEFT   = 2'd0,
        JUST_RIGHT  = 2'd1,
        JUST_CENTRE = 2'd2
    } just_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        just_e             just;
    } dot_cmd_t;

    localparam dot_cmd_t CMD_IDLE = '{code: CODE_NONE, just: JUST_LEFT};

    function automatic just_e decode_just(input logic single_edge, input logic lead_edge);
        if (!single_edge)   return JUST_CENTRE;
        else if (lead_edge) return JUST_RIGHT;
        else                return JUST_LEFT;
    endfunction

    // Decide whether a given sub-slot of the period is high for a command.
    function automatic logic slot_hit(input dot_cmd_t c, input logic [SLOT_W-1:0] s);
        logic [CODE_W:0] w;
        logic [CODE_W:0] sx;
        logic [CODE_W:0] lo;
        logic [CODE_W:0] hi;
        logic            hit;
        w   = {1'b0, c.code};
        sx  = {1'b0, s};
        lo  = HALF_X - (w >> 1);
        hi  = lo + w;
        hit = 1'b0;
        if (c.code == CODE_NONE) begin
            hit = 1'b0;
        end else if (c.code == CODE_FULL) begin
            hit = 1'b1;
        end else begin
            case (c.just)
                JUST_LEFT:   hit = (sx < w);
                JUST_RIGHT:  hit = ((sx + w) >= SLOTS_X);
                JUST_CENTRE: hit = (sx >= lo) && (sx < hi);
                default:     hit = 1'b0;
            endcase
        end
        return hit;
    endfunction

endpackage

// File: rtl/pwm_slot_counter.sv
module pwm_slot_counter
    import pwm_just_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    output logic [SLOT_W-1:0] slot_q,
    output logic [SLOT_W-1:0] slot_nxt
);

    always_comb begin
        if (!run)         slot_nxt = slot_q;
        else if (restart) slot_nxt = '0;
        else              slot_nxt = slot_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_nxt;
    end

endmodule

// File: rtl/pwm_cmd_pipe.sv
module pwm_cmd_pipe
    import pwm_just_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  dot_cmd_t cmd_in,
    output dot_cmd_t act_q,
    output dot_cmd_t act_nxt
);

    dot_cmd_t held_q;

    always_comb begin
        act_nxt = load ? held_q : act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= CMD_IDLE;
            act_q  <= CMD_IDLE;
        end else if (load) begin
            held_q <= cmd_in;
            act_q  <= held_q;
        end
    end

endmodule

// File: rtl/pwm_shaper.sv
module pwm_shaper
    import pwm_just_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              force_hi,
    input  dot_cmd_t          cmd,
    input  logic [SLOT_W-1:0] slot,
    output logic              pwm_q
);

    always_ff @(posedge clk) begin
        if (rst)           pwm_q <= 1'b0;
        else if (!run)     pwm_q <= 1'b0;
        else if (force_hi) pwm_q <= 1'b1;
        else               pwm_q <= slot_hit(cmd, slot);
    end

endmodule

// File: rtl/pwm_justify.sv
module pwm_justify
    import pwm_just_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dot_start,
    input  logic [CODE_W-1:0] width_code,
    input  logic              single_edge,
    input  logic              lead_edge,
    input  logic              retrace,
    input  logic              low_power_n,
    output logic              pwm_out
);

    dot_cmd_t          cmd_in;
    dot_cmd_t          act_q;
    dot_cmd_t          act_nxt;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;

    always_comb begin
        cmd_in.code = width_code;
        cmd_in.just = decode_just(single_edge, lead_edge);
    end

    pwm_cmd_pipe u_pipe (
        .clk     (clk),
        .rst     (rst),
        .load    (dot_start),
        .cmd_in  (cmd_in),
        .act_q   (act_q),
        .act_nxt (act_nxt)
    );

    pwm_slot_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (low_power_n),
        .restart  (dot_start),
        .slot_q   (slot_q),
        .slot_nxt (slot_nxt)
    );

    pwm_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .run      (low_power_n),
        .force_hi (retrace),
        .cmd      (act_nxt),
        .slot     (slot_nxt),
        .pwm_q    (pwm_out)
    );

endmodule

// File: rtl/pwm_justify_chk.sv
module pwm_justify_chk
    import pwm_just_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dot_start,
    input logic              retrace,
    input logic              low_power_n,
    input logic              pwm_out,
    input logic [SLOT_W-1:0] slot_q,
    input logic [CODE_W-1:0] act_code
);

    // R9
    park_low_chk: assert property (@(posedge clk) disable iff (rst)
        !low_power_n |=> !pwm_out);

    // R9
    slot_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !low_power_n |=> $stable(slot_q));

    // R8
    retrace_high_chk: assert property (@(posedge clk) disable iff (rst)
        (retrace && low_power_n) |=> pwm_out);

    // R6
    slot_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (dot_start && low_power_n) |=> (slot_q == '0));

    // R6
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (low_power_n && !dot_start) |=> (slot_q == $past(slot_q) + 1'b1));

    // R5
    full_code_chk: assert property (@(posedge clk) disable iff (rst)
        (act_code == CODE_FULL && low_power_n && !dot_start) |=> pwm_out);

    // R5
    zero_code_chk: assert property (@(posedge clk) disable iff (rst)
        (act_code == CODE_NONE && low_power_n && !retrace && !dot_start) |=> !pwm_out);

endmodule

bind pwm_justify pwm_justify_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dot_start   (dot_start),
    .retrace     (retrace),
    .low_power_n (low_power_n),
    .pwm_out     (pwm_out),
    .slot_q      (slot_q),
    .act_code    (act_q.code)
);

// File: tb/pwm_justify_bench.sv
module pwm_justify_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 256;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dot_start = 1'b0;
    logic [7:0] width_code = 8'd0;
    logic       single_edge = 1'b1;
    logic       lead_edge = 1'b0;
    logic       retrace = 1'b0;
    logic       low_power_n = 1'b1;
    logic       pwm_out;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    chk_en = 1'b0;

    // reference state
    int m_slot = 0;
    int h_code = 0, h_mode = 0;
    int a_code = 0, a_mode = 0;
    bit exp_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_justify u_pwm_justify (
        .clk         (clk),
        .rst         (rst),
        .dot_start   (dot_start),
        .width_code  (width_code),
        .single_edge (single_edge),
        .lead_edge   (lead_edge),
        .retrace     (retrace),
        .low_power_n (low_power_n),
        .pwm_out     (pwm_out)
    );

    // mode: 0 left, 1 right, 2 centre
    function automatic int mode_of(input bit s, input bit l);
        if (!s) return 2;
        return l ? 1 : 0;
    endfunction

    function automatic bit ref_level(input int code, input int mode, input int slot);
        int first;
        if (code == 0)   return 1'b0;
        if (code == 255) return 1'b1;
        if (mode == 0)      first = 0;
        else if (mode == 1) first = NSLOT - code;
        else                first = NSLOT/2 - code/2;
        return (slot >= first) && (slot < first + code);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_slot = 0; h_code = 0; h_mode = 0; a_code = 0; a_mode = 0;
            exp_out = 1'b0;
        end else begin
            if (low_power_n) m_slot = dot_start ? 0 : (m_slot + 1) % NSLOT;
            if (dot_start) begin
                a_code = h_code; a_mode = h_mode;
                h_code = width_code; h_mode = mode_of(single_edge, lead_edge);
            end
            if (!low_power_n) exp_out = 1'b0;
            else if (retrace) exp_out = 1'b1;
            else              exp_out = ref_level(a_code, a_mode, m_slot);
        end
    end

    always @(negedge clk) begin
        if (chk_en && !rst) begin
            checks++;
            if (pwm_out !== exp_out) begin
                errors++;
                $display("FAIL %s: t=%0t pwm_out=%b expected=%b", cur_req, $time, pwm_out, exp_out);
            end
        end
    end

    task automatic strobe(input int code, input bit s, input bit l);
        @(negedge clk);
        dot_start = 1'b1; width_code = 8'(code); single_edge = s; lead_edge = l;
        @(negedge clk);
        dot_start = 1'b0;
    endtask

    task automatic period(input int code, input bit s, input bit l);
        strobe(code, s, l);
        repeat (NSLOT - 2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: output low during reset
        checks++;
        if (pwm_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: pwm_out=%b expected=0 in reset", pwm_out);
        end
        @(negedge clk); rst = 1'b0;
        chk_en = 1'b1;
        cur_req = "R1";
        repeat (3) @(negedge clk);

        // R2 left-justified widths, R6 one-period latency
        cur_req = "R2/R6";
        period(1, 1, 0); period(2, 1, 0); period(100, 1, 0); period(254, 1, 0);
        // R3 right-justified widths
        cur_req = "R3";
        period(1, 1, 1); period(77, 1, 1); period(254, 1, 1);
        // R4 centred, lead_edge ignored, odd rounding
        cur_req = "R4";
        period(1, 0, 0); period(2, 0, 1); period(3, 0, 0); period(128, 0, 1); period(254, 0, 0);
        // R5 extreme codes in every placement
        cur_req = "R5";
        period(0, 1, 0); period(255, 1, 1); period(0, 0, 1); period(255, 1, 0);
        period(0, 1, 1); period(255, 0, 0);
        // R10 right full then left full, then right/left partial
        cur_req = "R10";
        period(255, 1, 1); period(255, 1, 0); period(200, 1, 1); period(90, 1, 0);
        // R7 placement and code change every period
        cur_req = "R7";
        period(33, 0, 0); period(34, 1, 1); period(35, 1, 0); period(0, 0, 0);

        // R8 retrace in mid period, then release
        cur_req = "R8";
        strobe(60, 1, 0);
        repeat (20) @(negedge clk);
        retrace = 1'b1;
        repeat (15) @(negedge clk);
        retrace = 1'b0;
        repeat (NSLOT - 2 - 35) @(negedge clk);

        // R11 power-reduce over retrace; R9 freeze incl. ignored strobe
        cur_req = "R9/R11";
        strobe(120, 0, 0);
        repeat (30) @(negedge clk);
        retrace = 1'b1; low_power_n = 1'b0;
        repeat (5) @(negedge clk);
        retrace = 1'b0;
        repeat (5) @(negedge clk);
        dot_start = 1'b1; width_code = 8'd40; single_edge = 1'b1; lead_edge = 1'b1;
        @(negedge clk);
        dot_start = 1'b0;
        repeat (10) @(negedge clk);
        low_power_n = 1'b1;
        repeat (300) @(negedge clk);
        period(10, 1, 0); period(0, 1, 0);
        repeat (4) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule